// File: doc/BRIEF.md
# Performance Counter Global Control and Overflow Status

This unit sits beside a bank of general-purpose event counters and a bank of fixed-function event counters. It does not count anything itself. It holds a global run mask, a packed control word for the fixed counters, and a sticky overflow status word. From these it derives the per-counter run signals and a single interrupt request toward the local interrupt controller. The counters return one-cycle overflow pulses. The unit gathers these pulses into status bits that software clears through a separate write-one-to-clear register.

General-purpose counter `n` and fixed counter `n` share one bit map. The general-purpose counter uses bit `n` and the fixed counter uses bit `FIX_BASE + n`, with `FIX_BASE` = 32 by default. Each fixed counter owns a 4-bit field of the fixed control word at offset `4*n`. In that field, bit 0 enables kernel-mode counting, bit 1 enables user-mode counting, bit 3 arms the overflow interrupt, and bit 2 is reserved. The interrupt enable of each general-purpose counter comes from its own event-select logic as an input.

The interrupt path is a two-state machine. In `IRQ_IDLE` the request is low. The transition *raise* goes from `IRQ_IDLE` to `IRQ_PEND` on any overflow whose interrupt is armed. In `IRQ_PEND` the request is held high. The transition *acknowledge* goes from `IRQ_PEND` back to `IRQ_IDLE` when `irq_ack` is high and no armed overflow arrives in the same cycle. An armed overflow in that cycle keeps the machine in `IRQ_PEND` (*re-raise*). The register selector codes are 0 = run mask, 1 = overflow status, 2 = overflow clear, 3 = fixed control.

Top module: `pmu_glb_ctrl`

## Requirements
- R1: After reset, every register reads zero, every run output is low and `irq_req` is low.
- R2: A write with selector 0 sets the run mask. `gp_run[n]` equals run-mask bit `n` from the cycle after the write.
- R3: `fix_run_kern[n]` is run-mask bit `32+n` AND fixed field bit `4n`, and `fix_run_user[n]` is run-mask bit `32+n` AND fixed field bit `4n+1`. Clearing a field, or its run-mask bit, stops that counter in the next cycle.
- R4: An overflow pulse on general-purpose counter `n` sets status bit `n`, and one on fixed counter `n` sets status bit `32+n`. The bit is visible at selector 1 in the next cycle and stays set until cleared.
- R5: A write with selector 2 clears exactly the status bits that are 1 in the written value and keeps the others. Writing back a status value read earlier clears all of them.
- R6: When an overflow and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: A write with selector 1 leaves the status unchanged, and selector 2 always reads zero.
- R8: `irq_req` rises in the cycle after an overflow whose interrupt is armed. A general-purpose counter is armed by `gp_irq_en[n]`, and a fixed counter by field bit `4n+3`. An unarmed overflow still sets status but does not raise the request.
- R9: Once raised, `irq_req` stays high until a cycle with `irq_ack` high. An armed overflow in the same cycle as the acknowledge keeps it high.
- R10: Run-mask bits with no counter behind them, and reserved bit 2 of every fixed field, ignore writes and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector (0 run mask, 1 status, 2 clear, 3 fixed control) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| gp_ovf | input | NUM_GP | Overflow pulses from the general-purpose counters |
| gp_irq_en | input | NUM_GP | Interrupt arm per general-purpose counter |
| fix_ovf | input | NUM_FIX | Overflow pulses from the fixed counters |
| irq_ack | input | 1 | Acknowledge of the interrupt request |
| gp_run | output | NUM_GP | Run enable per general-purpose counter |
| fix_run_kern | output | NUM_FIX | Kernel-mode count enable per fixed counter |
| fix_run_user | output | NUM_FIX | User-mode count enable per fixed counter |
| irq_req | output | 1 | Level interrupt request |

## Verification
A corrupted status bit shows at selector 1 in the first read after the faulty edge. A wrong run-mask or field bit shows on the run outputs in the next cycle. A wrong interrupt state shows on `irq_req` one cycle after the overflow or acknowledge that should have moved it. The bench keeps its own model of all three registers and the request level, and compares every output on every clock. A fault therefore surfaces within one cycle of the stimulus that exposes it.

// File: rtl/pmu_glb_pkg.sv
package pmu_glb_pkg;

    typedef enum logic [1:0] {
        SEL_RUN    = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_FIXCFG = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    localparam int FIELD_W = 4;
    localparam int FLD_KERN = 0;
    localparam int FLD_USER = 1;
    localparam int FLD_PMI  = 3;

endpackage

// File: rtl/pglb_cfg.sv
module pglb_cfg
    import pmu_glb_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_GP   = 4,
    parameter int NUM_FIX  = 3,
    parameter int FIX_BASE = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [1:0]                reg_sel,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         run_q,
    output logic [NUM_FIX*FIELD_W-1:0] fix_q,
    output logic [DATA_W-1:0]         clr_mask
);

    localparam int FIX_W = NUM_FIX * FIELD_W;

    function automatic logic [DATA_W-1:0] run_mask_f();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_GP; i++) m[i] = 1'b1;
        for (int i = 0; i < NUM_FIX; i++) m[FIX_BASE+i] = 1'b1;
        return m;
    endfunction

    function automatic logic [FIX_W-1:0] fix_mask_f();
        logic [FIX_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_FIX; i++) begin
            m[i*FIELD_W+FLD_KERN] = 1'b1;
            m[i*FIELD_W+FLD_USER] = 1'b1;
            m[i*FIELD_W+FLD_PMI]  = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] RUN_MASK = run_mask_f();
    localparam logic [FIX_W-1:0]  FIX_MASK = fix_mask_f();

    logic wr_run, wr_fix, wr_clr;

    always_comb begin
        wr_run = 1'b0;
        wr_fix = 1'b0;
        wr_clr = 1'b0;
        if (reg_wr) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_RUN:    wr_run = 1'b1;
                SEL_FIXCFG: wr_fix = 1'b1;
                SEL_CLEAR:  wr_clr = 1'b1;
                SEL_STATUS: ;
            endcase
        end
    end

    assign clr_mask = wr_clr ? reg_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            fix_q <= '0;
        end else begin
            if (wr_run) run_q <= reg_wdata & RUN_MASK;
            if (wr_fix) fix_q <= reg_wdata[FIX_W-1:0] & FIX_MASK;
        end
    end

endmodule

// File: rtl/pglb_ovf.sv
module pglb_ovf #(
    parameter int DATA_W   = 64,
    parameter int NUM_GP   = 4,
    parameter int NUM_FIX  = 3,
    parameter int FIX_BASE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_GP-1:0] gp_ovf,
    input  logic [NUM_FIX-1:0] fix_ovf,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] stat_q
);

    logic [DATA_W-1:0] hit_vec;

    always_comb begin
        hit_vec = '0;
        hit_vec[NUM_GP-1:0] = gp_ovf;
        hit_vec[FIX_BASE +: NUM_FIX] = fix_ovf;
    end

    // a new overflow takes precedence over a clear of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | hit_vec;
    end

endmodule

// File: rtl/pglb_irq.sv
module pglb_irq
    import pmu_glb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic irq_req
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (raise) state_d = IRQ_PEND;
            IRQ_PEND: if (ack && !raise) state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_IDLE: irq_req = 1'b0;
            IRQ_PEND: irq_req = 1'b1;
        endcase
    end

endmodule

// File: rtl/pmu_glb_ctrl.sv
module pmu_glb_ctrl
    import pmu_glb_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_GP   = 4,
    parameter int NUM_FIX  = 3,
    parameter int FIX_BASE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_GP-1:0]  gp_ovf,
    input  logic [NUM_GP-1:0]  gp_irq_en,
    input  logic [NUM_FIX-1:0] fix_ovf,
    input  logic               irq_ack,
    output logic [NUM_GP-1:0]  gp_run,
    output logic [NUM_FIX-1:0] fix_run_kern,
    output logic [NUM_FIX-1:0] fix_run_user,
    output logic               irq_req
);

    localparam int FIX_W = NUM_FIX * FIELD_W;

    logic [DATA_W-1:0]  run_q;
    logic [FIX_W-1:0]   fix_q;
    logic [DATA_W-1:0]  clr_mask;
    logic [DATA_W-1:0]  stat_q;
    logic [NUM_FIX-1:0] fix_pmi;
    logic               raise;

    pglb_cfg #(
        .DATA_W(DATA_W), .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .FIX_BASE(FIX_BASE)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .run_q(run_q), .fix_q(fix_q), .clr_mask(clr_mask)
    );

    pglb_ovf #(
        .DATA_W(DATA_W), .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .FIX_BASE(FIX_BASE)
    ) ovf_i (
        .clk(clk), .rst_n(rst_n), .gp_ovf(gp_ovf), .fix_ovf(fix_ovf),
        .clr_mask(clr_mask), .stat_q(stat_q)
    );

    assign gp_run = run_q[NUM_GP-1:0];

    for (genvar i = 0; i < NUM_FIX; i++) begin : g_fix
        assign fix_run_kern[i] = run_q[FIX_BASE+i] & fix_q[i*FIELD_W+FLD_KERN];
        assign fix_run_user[i] = run_q[FIX_BASE+i] & fix_q[i*FIELD_W+FLD_USER];
        assign fix_pmi[i]      = fix_q[i*FIELD_W+FLD_PMI];
    end

    assign raise = (|(gp_ovf & gp_irq_en)) | (|(fix_ovf & fix_pmi));

    pglb_irq irq_i (
        .clk(clk), .rst_n(rst_n), .raise(raise), .ack(irq_ack), .irq_req(irq_req)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_sel))
            SEL_RUN:    reg_rdata = run_q;
            SEL_STATUS: reg_rdata = stat_q;
            SEL_CLEAR:  reg_rdata = '0;
            SEL_FIXCFG: reg_rdata[FIX_W-1:0] = fix_q;
        endcase
    end

endmodule

// File: rtl/pmu_glb_ctrl_chk.sv
module pmu_glb_ctrl_chk #(
    parameter int DATA_W   = 64,
    parameter int NUM_GP   = 4,
    parameter int NUM_FIX  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [1:0]         reg_sel,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [NUM_GP-1:0]  gp_ovf,
    input logic [NUM_GP-1:0]  gp_irq_en,
    input logic [NUM_FIX-1:0] fix_ovf,
    input logic               irq_ack,
    input logic               irq_req,
    input logic [DATA_W-1:0]  stat_q
);

    logic clr0;
    assign clr0 = reg_wr && (reg_sel == 2'd2) && reg_wdata[0];

    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (stat_q == '0 && !irq_req));

    a_r4_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        gp_ovf[0] |=> stat_q[0]);

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !clr0) |=> stat_q[0]);

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && !gp_ovf[0]) |=> !stat_q[0]);

    a_r6_ovf_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && gp_ovf[0]) |=> stat_q[0]);

    a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gp_ovf & gp_irq_en)) |=> irq_req);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && gp_ovf == '0 && fix_ovf == '0) |=> !irq_req);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req);

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && gp_ovf == '0 && fix_ovf == '0) |=> !irq_req);

endmodule

bind pmu_glb_ctrl pmu_glb_ctrl_chk #(
    .DATA_W(DATA_W), .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .gp_ovf(gp_ovf), .gp_irq_en(gp_irq_en),
    .fix_ovf(fix_ovf), .irq_ack(irq_ack), .irq_req(irq_req), .stat_q(stat_q)
);

// File: tb/pmu_glb_ctrl_tb_top.sv
module pmu_glb_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NGP = 4;
    localparam int NFX = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [NGP-1:0] gp_ovf = '0, gp_irq_en = '0;
    logic [NFX-1:0] fix_ovf = '0;
    logic        irq_ack = 1'b0;
    logic [NGP-1:0] gp_run;
    logic [NFX-1:0] fix_run_kern, fix_run_user;
    logic        irq_req;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural model state
    logic [63:0] m_run = '0, m_stat = '0, m_fix = '0;
    logic        m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmu_glb_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gp_ovf(gp_ovf),
        .gp_irq_en(gp_irq_en), .fix_ovf(fix_ovf), .irq_ack(irq_ack),
        .gp_run(gp_run), .fix_run_kern(fix_run_kern),
        .fix_run_user(fix_run_user), .irq_req(irq_req)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] m_read(logic [1:0] s);
        case (s)
            2'd0: return m_run;
            2'd1: return m_stat;
            2'd3: return m_fix;
            default: return 64'd0;
        endcase
    endfunction

    task automatic model_edge();
        logic [63:0] clr, hit, run_msk, fix_msk;
        logic armed;
        run_msk = 64'h0000_0007_0000_000F;
        fix_msk = 64'h0000_0000_0000_0BBB;
        clr = (reg_wr && reg_sel == 2'd2) ? reg_wdata : 64'd0;
        hit = {29'd0, fix_ovf, 28'd0, gp_ovf};
        armed = 1'b0;
        for (int i = 0; i < NGP; i++) if (gp_ovf[i] && gp_irq_en[i]) armed = 1'b1;
        for (int i = 0; i < NFX; i++) if (fix_ovf[i] && m_fix[4*i+3]) armed = 1'b1;
        m_stat = (m_stat & ~clr) | hit;
        if (armed) m_irq = 1'b1;
        else if (irq_ack) m_irq = 1'b0;
        if (reg_wr && reg_sel == 2'd0) m_run = reg_wdata & run_msk;
        if (reg_wr && reg_sel == 2'd3) m_fix = reg_wdata & fix_msk;
    endtask

    task automatic compare_all();
        logic [NFX-1:0] ek, eu;
        for (int i = 0; i < NFX; i++) begin
            ek[i] = m_run[32+i] & m_fix[4*i];
            eu[i] = m_run[32+i] & m_fix[4*i+1];
        end
        chk("R2 gp_run", {60'd0, gp_run}, {60'd0, m_run[3:0]});
        chk("R3 fix_run_kern", {61'd0, fix_run_kern}, {61'd0, ek});
        chk("R3 fix_run_user", {61'd0, fix_run_user}, {61'd0, eu});
        chk("R8 irq_req", {63'd0, irq_req}, {63'd0, m_irq});
        chk("R4 reg_rdata", reg_rdata, m_read(reg_sel));
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        reg_wr = 1'b0; gp_ovf = '0; fix_ovf = '0; irq_ack = 1'b0;
    endtask

    task automatic wr(logic [1:0] s, logic [63:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        step();
        idle();
    endtask

    task automatic rd(logic [1:0] s);
        reg_sel = s;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 rdata run", reg_rdata, 64'd0);
        chk("R1 irq", {63'd0, irq_req}, 64'd0);
        rst_n = 1'b1;
        rd(2'd1);
        chk("R1 status", reg_rdata, 64'd0);
        rd(2'd3);
        chk("R1 fixcfg", reg_rdata, 64'd0);

        // R2/R10: run mask with unimplemented bits
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd0);
        chk("R10 run mask readback", reg_rdata, 64'h0000_0007_0000_000F);
        chk("R2 gp_run all", {60'd0, gp_run}, 64'hF);

        // R3/R10: fixed fields, reserved bit 2 set in field 0
        wr(2'd3, 64'h0000_0000_0000_021F);
        rd(2'd3);
        chk("R10 fix reserved bit", reg_rdata, 64'h21B);
        chk("R3 kern", {61'd0, fix_run_kern}, 64'b011);
        chk("R3 user", {61'd0, fix_run_user}, 64'b101);

        // R3: clearing field 1 stops fixed counter 1
        wr(2'd3, 64'h0000_0000_0000_020B);
        chk("R3 field clear stops", {61'd0, fix_run_kern}, 64'b001);
        // R3: global bit 32+2 off stops fixed counter 2
        wr(2'd0, 64'h0000_0003_0000_0005);
        chk("R3 global off", {61'd0, fix_run_user}, 64'b001);
        chk("R2 gp_run pattern", {60'd0, gp_run}, 64'h5);

        // R4/R8: unarmed gp overflow
        reg_sel = 2'd1; gp_ovf = 4'b0100;
        step(); idle();
        chk("R4 gp2 status", reg_rdata, 64'h4);
        chk("R8 unarmed no irq", {63'd0, irq_req}, 64'd0);

        // R8: armed fixed 0 overflow
        fix_ovf = 3'b001;
        step(); idle();
        chk("R4 fix0 status bit32", reg_rdata, 64'h1_0000_0004);
        chk("R8 armed irq", {63'd0, irq_req}, 64'd1);

        // R9: hold, then ack
        step(); step();
        chk("R9 held", {63'd0, irq_req}, 64'd1);
        irq_ack = 1'b1; step(); idle();
        chk("R9 ack drops", {63'd0, irq_req}, 64'd0);

        // R8 via gp arm; R9 ack with armed overflow keeps level
        gp_irq_en = 4'b0010; gp_ovf = 4'b0010;
        step(); idle();
        chk("R8 gp armed", {63'd0, irq_req}, 64'd1);
        irq_ack = 1'b1; gp_ovf = 4'b0010;
        step(); idle();
        chk("R9 reraise", {63'd0, irq_req}, 64'd1);
        irq_ack = 1'b1; step(); idle();

        // R8: fixed 2 unarmed
        fix_ovf = 3'b100; step(); idle();
        chk("R8 fix2 unarmed", {63'd0, irq_req}, 64'd0);

        // R7: writes to status ignored, clear reads zero
        wr(2'd1, 64'd0);
        rd(2'd1);
        chk("R7 status write ignored", reg_rdata, 64'h5_0000_0006);
        rd(2'd2);
        chk("R7 clear reads zero", reg_rdata, 64'd0);

        // R5: partial clear keeps other bits
        wr(2'd2, 64'h4_0000_0002);
        rd(2'd1);
        chk("R5 partial clear", reg_rdata, 64'h1_0000_0004);

        // R6: overflow and clear on same bit
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 64'h1; gp_ovf = 4'b0001;
        step(); idle();
        rd(2'd1);
        chk("R6 overflow wins", reg_rdata, 64'h1_0000_0005);

        // R5: write back the read value clears all
        wr(2'd2, 64'h1_0000_0005);
        rd(2'd1);
        chk("R5 full clear", reg_rdata, 64'd0);

        repeat (4) step();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule